// File: doc/BRIEF.md
# Tone Signalling Configuration Sequencer

This block keeps the tone-signalling codec of each radio channel in step with that channel's state. It holds one request flag per channel. A channel's flag is raised whenever its receive or transmit activity, its detected code or its configured codes change. When it is idle, the sequencer picks one flagged channel by round-robin and takes a snapshot of that channel's settings. It then works out which squelch mode applies in each direction: digital code, continuous tone, or none. Finally it writes the matching configuration to the codec through an external serial command engine, one command at a time.

Each step issues at most one command. A step is taken only when the engine reports not busy and no command left in the cycle before. Steps whose condition is false advance with no command. The code-to-byte lookup tables sit outside the block: the sequencer presents a 15-bit key, and the table's bytes come back on input ports in the same cycle. The sequence always ends by writing two accumulated mask bytes, setup first and then control.

Top module: `tone_cfg_seq`

## Requirements
- R1: A step is taken only in a cycle where `busy_i` is low and `cmd_valid_o` is low. Each step moves the sequence forward by exactly one state. So a command never follows a busy cycle, and two commands are never adjacent.
- R2: A one-cycle pulse on `req_i[c]` sets channel c's request flag. When idle, a step accepts a flagged channel and clears its flag, unless a new pulse for that channel arrives in the same cycle. With no flag set, no command is ever issued.
- R3: Receive runs in digital mode when receive slot 0 of the channel is nonzero. Otherwise it runs in tone mode if any of receive slots 1 and up is nonzero.
- R4: The transmit code is taken from the transmit slot given by `det_code_i`. This holds only when the channel is receiving, receive is in tone mode and the detected code is nonzero; in every other case slot 0 is used. A code with bit 15 set selects digital transmit. Any other nonzero code selects tone transmit.
- R5: Both transmit modes are forced off when `no_enc_i` is set, when `tx_act_i` is low, or when `burst_i` is high.
- R6: Digital transmit runs only when digital receive is off. It issues op 0x84, then 0x85, then 0x86, each carrying one key byte: `b1` = `dig_bytes_i[23:16]`, `[15:8]` and `[7:0]` in turn, with the key equal to transmit code bits 14:0. It ORs 0x03 into the setup mask and 0x80 into the control mask.
- R7: Tone transmit issues op 0x83 with `b1` = `tone_bytes_i[15:8]` and `b2` = `tone_bytes_i[7:0]`, keyed by transmit code bits 14:0. It ORs 0x80 into the control mask.
- R8: Digital receive issues ops 0x84, 0x85 and 0x86 keyed by receive slot 0 bits 14:0. It ORs 0x01 into the setup mask and 0x41 into the control mask.
- R9: Tone receive ORs 0x80 into the setup mask and 0x60 into the control mask. Every sequence ends with op 0x8B, carrying the setup mask, then op 0x8A, carrying the control mask. One further step returns the sequencer to idle. Every command carries the accepted channel on `cmd_chan_o`.
- R10: The command order is: digital-transmit group, tone-transmit command, digital-receive group, setup write, control write. A group whose condition is false issues nothing.
- R11: Acceptance is round-robin. The search starts at the channel after the last one accepted, so a channel that is flagged again cannot be served twice while another flagged channel waits.
- R12: After reset, no command is valid, every request flag is clear, the sequencer is idle and the search starts at channel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | NUM_CH | Per-channel request pulse |
| busy_i | input | 1 | Command engine busy |
| rx_act_i | input | NUM_CH | Channel is receiving |
| tx_act_i | input | NUM_CH | Channel is transmitting |
| burst_i | input | NUM_CH | Burst timer running |
| no_enc_i | input | NUM_CH | No-encode mode |
| det_code_i | input | NUM_CH*IDX_W | Detected tone code per channel |
| rx_code_i | input | NUM_CH*NUM_SLOTS*CODE_W | Receive code slots, channel-major |
| tx_code_i | input | NUM_CH*NUM_SLOTS*CODE_W | Transmit code slots, channel-major |
| dig_key_o | output | CODE_W-1 | Digital code table key |
| dig_bytes_i | input | 24 | Digital code table bytes for key |
| tone_key_o | output | CODE_W-1 | Tone table key |
| tone_bytes_i | input | 16 | Tone table bytes for key |
| cmd_valid_o | output | 1 | Command strobe, one cycle |
| cmd_chan_o | output | CH_W | Target channel |
| cmd_op_o | output | 8 | Command opcode |
| cmd_b1_o | output | 8 | First data byte |
| cmd_b2_o | output | 8 | Second data byte (tone command only) |

## Verification
The assertions assume that the channel inputs of a flagged channel are steady from the pulse to acceptance, and that the table bytes settle in the same cycle as the key. The bench changes channel settings only while no sequence is running, and its table model is combinational. The assertions also assume `busy_i` goes high only as a result of a command. The bench's engine model raises busy for a fixed three cycles after every command and never on its own.

// File: rtl/tsq_pkg.sv
package tsq_pkg;

  // order is the command order
  typedef enum logic [3:0] {
    S_IDLE  = 4'd0,
    S_TXD1  = 4'd1,
    S_TXD2  = 4'd2,
    S_TXD3  = 4'd3,
    S_TXT   = 4'd4,
    S_RXD1  = 4'd5,
    S_RXD2  = 4'd6,
    S_RXD3  = 4'd7,
    S_SETUP = 4'd8,
    S_CTRL  = 4'd9,
    S_DONE  = 4'd10
  } seq_state_e;

  typedef struct packed {
    logic dtx;
    logic ttx;
    logic drx;
    logic trx;
  } mode_t;

  localparam logic [7:0] SETUP_DTX = 8'h03;
  localparam logic [7:0] CTRL_DTX  = 8'h80;
  localparam logic [7:0] CTRL_TTX  = 8'h80;
  localparam logic [7:0] SETUP_DRX = 8'h01;
  localparam logic [7:0] CTRL_DRX  = 8'h41;
  localparam logic [7:0] SETUP_TRX = 8'h80;
  localparam logic [7:0] CTRL_TRX  = 8'h60;

endpackage

// File: rtl/tsq_req_arb.sv
module tsq_req_arb #(
  parameter int NUM_CH = 4,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] req_i,
  input  logic              accept_i,
  output logic              found_o,
  output logic [CH_W-1:0]   pick_o
);

  logic [NUM_CH-1:0] flags_q, clr_mask;
  logic [CH_W-1:0]   ptr_q;

  always_comb begin
    found_o = 1'b0;
    pick_o  = '0;
    for (int k = 0; k < NUM_CH; k++) begin
      int idx;
      idx = (int'(ptr_q) + k) % NUM_CH;
      if (!found_o && flags_q[idx]) begin
        found_o = 1'b1;
        pick_o  = CH_W'(idx);
      end
    end
  end

  always_comb begin
    clr_mask = '0;
    if (accept_i) clr_mask[pick_o] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      ptr_q   <= '0;
    end else begin
      flags_q <= (flags_q & ~clr_mask) | req_i;
      if (accept_i) ptr_q <= (int'(pick_o) == NUM_CH - 1) ? '0 : pick_o + 1'b1;
    end
  end

  assert_accept_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_i && !req_i[pick_o]) |=> !flags_q[$past(pick_o)]);

  assert_accept_flagged_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |-> flags_q[pick_o]);

endmodule

// File: rtl/tsq_mode_dec.sv
module tsq_mode_dec
  import tsq_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int CODE_W    = 16,
  localparam int IDX_W    = $clog2(NUM_SLOTS),
  localparam int SLOT_BITS = NUM_SLOTS * CODE_W
) (
  input  logic [SLOT_BITS-1:0] rx_codes_i,
  input  logic [SLOT_BITS-1:0] tx_codes_i,
  input  logic [IDX_W-1:0]     det_i,
  input  logic                 rx_act_i,
  input  logic                 tx_act_i,
  input  logic                 burst_i,
  input  logic                 no_enc_i,
  output mode_t                mode_o,
  output logic [CODE_W-2:0]    tx_key_o,
  output logic [CODE_W-2:0]    rx_key_o
);

  logic [NUM_SLOTS-1:0] slot_nz;
  logic                 tone_any, drx, trx, hold_off;
  logic [IDX_W-1:0]     tx_idx;
  logic [CODE_W-1:0]    tx_code, rx_slot0;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    assign slot_nz[s] = |rx_codes_i[s*CODE_W +: CODE_W];
  end

  assign rx_slot0 = rx_codes_i[CODE_W-1:0];
  assign tone_any = |slot_nz[NUM_SLOTS-1:1];
  assign drx      = slot_nz[0];
  assign trx      = !drx && tone_any;

  assign tx_idx   = (rx_act_i && trx && (det_i != '0)) ? det_i : '0;
  assign tx_code  = tx_codes_i[int'(tx_idx)*CODE_W +: CODE_W];
  assign hold_off = no_enc_i || !tx_act_i || burst_i;

  assign mode_o.drx = drx;
  assign mode_o.trx = trx;
  assign mode_o.dtx = !hold_off && tx_code[CODE_W-1];
  assign mode_o.ttx = !hold_off && !tx_code[CODE_W-1] && (|tx_code[CODE_W-2:0]);

  assign tx_key_o = tx_code[CODE_W-2:0];
  assign rx_key_o = rx_slot0[CODE_W-2:0];

endmodule

// File: rtl/tsq_seq_fsm.sv
module tsq_seq_fsm
  import tsq_pkg::*;
#(
  parameter int         CH_W     = 2,
  parameter int         CODE_W   = 16,
  parameter logic [7:0] OP_DIG1  = 8'h84,
  parameter logic [7:0] OP_DIG2  = 8'h85,
  parameter logic [7:0] OP_DIG3  = 8'h86,
  parameter logic [7:0] OP_TONE  = 8'h83,
  parameter logic [7:0] OP_SETUP = 8'h8B,
  parameter logic [7:0] OP_CTRL  = 8'h8A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic              found_i,
  input  logic [CH_W-1:0]   pick_i,
  input  mode_t             mode_i,
  input  logic [CODE_W-2:0] tx_key_i,
  input  logic [CODE_W-2:0] rx_key_i,
  input  logic [23:0]       dig_bytes_i,
  input  logic [15:0]       tone_bytes_i,
  output logic              accept_o,
  output logic [CODE_W-2:0] dig_key_o,
  output logic [CODE_W-2:0] tone_key_o,
  output logic              cmd_valid_o,
  output logic [CH_W-1:0]   cmd_chan_o,
  output logic [7:0]        cmd_op_o,
  output logic [7:0]        cmd_b1_o,
  output logic [7:0]        cmd_b2_o
);

  seq_state_e        state_q, state_n;
  mode_t             mode_q;
  logic [CH_W-1:0]   chan_q;
  logic [CODE_W-2:0] txk_q, rxk_q;
  logic [7:0]        setup_q, setup_n, ctrl_q, ctrl_n;
  logic              cmd_valid_q, step, issue;
  logic [7:0]        op_n, b1_n, b2_n;
  logic [7:0]        op_q, b1_q, b2_q;
  logic              in_tx_dig;

  assign step     = !busy_i && !cmd_valid_q;
  assign accept_o = step && (state_q == S_IDLE) && found_i;

  assign in_tx_dig  = (state_q == S_TXD1) || (state_q == S_TXD2) || (state_q == S_TXD3);
  assign dig_key_o  = in_tx_dig ? txk_q : rxk_q;
  assign tone_key_o = txk_q;

  always_comb begin
    state_n = state_q;
    setup_n = setup_q;
    ctrl_n  = ctrl_q;
    issue   = 1'b0;
    op_n    = '0;
    b1_n    = '0;
    b2_n    = '0;
    unique case (state_q)
      S_IDLE: begin
        setup_n = '0;
        ctrl_n  = '0;
        if (found_i) state_n = S_TXD1;
      end
      S_TXD1: begin
        if (mode_q.dtx && !mode_q.drx) begin
          setup_n = setup_q | SETUP_DTX;
          ctrl_n  = ctrl_q | CTRL_DTX;
          issue   = 1'b1;
          op_n    = OP_DIG1;
          b1_n    = dig_bytes_i[23:16];
          state_n = S_TXD2;
        end else begin
          state_n = S_TXT;
        end
      end
      S_TXD2: begin
        issue   = 1'b1;
        op_n    = OP_DIG2;
        b1_n    = dig_bytes_i[15:8];
        state_n = S_TXD3;
      end
      S_TXD3: begin
        issue   = 1'b1;
        op_n    = OP_DIG3;
        b1_n    = dig_bytes_i[7:0];
        state_n = S_TXT;
      end
      S_TXT: begin
        if (mode_q.ttx) begin
          ctrl_n = ctrl_q | CTRL_TTX;
          issue  = 1'b1;
          op_n   = OP_TONE;
          b1_n   = tone_bytes_i[15:8];
          b2_n   = tone_bytes_i[7:0];
        end
        state_n = S_RXD1;
      end
      S_RXD1: begin
        if (mode_q.drx) begin
          setup_n = setup_q | SETUP_DRX;
          ctrl_n  = ctrl_q | CTRL_DRX;
          issue   = 1'b1;
          op_n    = OP_DIG1;
          b1_n    = dig_bytes_i[23:16];
          state_n = S_RXD2;
        end else begin
          state_n = S_SETUP;
        end
      end
      S_RXD2: begin
        issue   = 1'b1;
        op_n    = OP_DIG2;
        b1_n    = dig_bytes_i[15:8];
        state_n = S_RXD3;
      end
      S_RXD3: begin
        issue   = 1'b1;
        op_n    = OP_DIG3;
        b1_n    = dig_bytes_i[7:0];
        state_n = S_SETUP;
      end
      S_SETUP: begin
        if (mode_q.trx) begin
          setup_n = setup_q | SETUP_TRX;
          ctrl_n  = ctrl_q | CTRL_TRX;
        end
        issue   = 1'b1;
        op_n    = OP_SETUP;
        b1_n    = setup_n;
        state_n = S_CTRL;
      end
      S_CTRL: begin
        issue   = 1'b1;
        op_n    = OP_CTRL;
        b1_n    = ctrl_q;
        state_n = S_DONE;
      end
      S_DONE:  state_n = S_IDLE;
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      mode_q      <= '0;
      chan_q      <= '0;
      txk_q       <= '0;
      rxk_q       <= '0;
      setup_q     <= '0;
      ctrl_q      <= '0;
      cmd_valid_q <= 1'b0;
      op_q        <= '0;
      b1_q        <= '0;
      b2_q        <= '0;
    end else begin
      cmd_valid_q <= step && issue;
      if (step) begin
        state_q <= state_n;
        setup_q <= setup_n;
        ctrl_q  <= ctrl_n;
        if (issue) begin
          op_q <= op_n;
          b1_q <= b1_n;
          b2_q <= b2_n;
        end
      end
      if (accept_o) begin
        chan_q <= pick_i;
        mode_q <= mode_i;
        txk_q  <= tx_key_i;
        rxk_q  <= rx_key_i;
      end
    end
  end

  assign cmd_valid_o = cmd_valid_q;
  assign cmd_chan_o  = chan_q;
  assign cmd_op_o    = op_q;
  assign cmd_b1_o    = b1_q;
  assign cmd_b2_o    = b2_q;

  assert_no_cmd_after_busy_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_q |-> !$past(busy_i));

  assert_cmd_spaced_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_q |=> !cmd_valid_q);

  assert_hold_when_stalled_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step |=> $stable(state_q));

  assert_dig_tx_gated_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_TXD2 || state_q == S_TXD3) |-> (mode_q.dtx && !mode_q.drx));

  assert_dig_rx_gated_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_RXD2 || state_q == S_RXD3) |-> mode_q.drx);

  assert_done_to_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_DONE && step) |=> (state_q == S_IDLE));

endmodule

// File: rtl/tone_cfg_seq.sv
module tone_cfg_seq
  import tsq_pkg::*;
#(
  parameter int         NUM_CH    = 4,
  parameter int         NUM_SLOTS = 4,
  parameter int         CODE_W    = 16,
  parameter logic [7:0] OP_DIG1   = 8'h84,
  parameter logic [7:0] OP_DIG2   = 8'h85,
  parameter logic [7:0] OP_DIG3   = 8'h86,
  parameter logic [7:0] OP_TONE   = 8'h83,
  parameter logic [7:0] OP_SETUP  = 8'h8B,
  parameter logic [7:0] OP_CTRL   = 8'h8A,
  localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int IDX_W     = $clog2(NUM_SLOTS),
  localparam int SLOT_BITS = NUM_SLOTS * CODE_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_CH-1:0]           req_i,
  input  logic                        busy_i,
  input  logic [NUM_CH-1:0]           rx_act_i,
  input  logic [NUM_CH-1:0]           tx_act_i,
  input  logic [NUM_CH-1:0]           burst_i,
  input  logic [NUM_CH-1:0]           no_enc_i,
  input  logic [NUM_CH*IDX_W-1:0]     det_code_i,
  input  logic [NUM_CH*SLOT_BITS-1:0] rx_code_i,
  input  logic [NUM_CH*SLOT_BITS-1:0] tx_code_i,
  output logic [CODE_W-2:0]           dig_key_o,
  input  logic [23:0]                 dig_bytes_i,
  output logic [CODE_W-2:0]           tone_key_o,
  input  logic [15:0]                 tone_bytes_i,
  output logic                        cmd_valid_o,
  output logic [CH_W-1:0]             cmd_chan_o,
  output logic [7:0]                  cmd_op_o,
  output logic [7:0]                  cmd_b1_o,
  output logic [7:0]                  cmd_b2_o
);

  logic              found, accept;
  logic [CH_W-1:0]   pick;
  mode_t             mode;
  logic [CODE_W-2:0] tx_key, rx_key;

  tsq_req_arb #(.NUM_CH(NUM_CH)) i_arb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .accept_i(accept),
    .found_o (found),
    .pick_o  (pick)
  );

  tsq_mode_dec #(.NUM_SLOTS(NUM_SLOTS), .CODE_W(CODE_W)) i_dec (
    .rx_codes_i(rx_code_i[int'(pick)*SLOT_BITS +: SLOT_BITS]),
    .tx_codes_i(tx_code_i[int'(pick)*SLOT_BITS +: SLOT_BITS]),
    .det_i     (det_code_i[int'(pick)*IDX_W +: IDX_W]),
    .rx_act_i  (rx_act_i[pick]),
    .tx_act_i  (tx_act_i[pick]),
    .burst_i   (burst_i[pick]),
    .no_enc_i  (no_enc_i[pick]),
    .mode_o    (mode),
    .tx_key_o  (tx_key),
    .rx_key_o  (rx_key)
  );

  tsq_seq_fsm #(
    .CH_W(CH_W), .CODE_W(CODE_W),
    .OP_DIG1(OP_DIG1), .OP_DIG2(OP_DIG2), .OP_DIG3(OP_DIG3),
    .OP_TONE(OP_TONE), .OP_SETUP(OP_SETUP), .OP_CTRL(OP_CTRL)
  ) i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .busy_i      (busy_i),
    .found_i     (found),
    .pick_i      (pick),
    .mode_i      (mode),
    .tx_key_i    (tx_key),
    .rx_key_i    (rx_key),
    .dig_bytes_i (dig_bytes_i),
    .tone_bytes_i(tone_bytes_i),
    .accept_o    (accept),
    .dig_key_o   (dig_key_o),
    .tone_key_o  (tone_key_o),
    .cmd_valid_o (cmd_valid_o),
    .cmd_chan_o  (cmd_chan_o),
    .cmd_op_o    (cmd_op_o),
    .cmd_b1_o    (cmd_b1_o),
    .cmd_b2_o    (cmd_b2_o)
  );

endmodule

// File: tb/test_tone_cfg_seq.sv
module test_tone_cfg_seq;

  localparam int NCH = 4;
  localparam int NSL = 4;
  localparam int CW  = 16;
  localparam int SB  = NSL * CW;

  typedef struct packed {
    logic [15:0] rx0;
    logic [15:0] rx1;
    logic [15:0] tx0;
    logic [15:0] tx2;
    logic [1:0]  det;
    logic        ract;
    logic        tact;
    logic        burst;
    logic        noenc;
    logic        g_dtx;
    logic        g_ttx;
    logic        g_drx;
    logic [7:0]  setup;
    logic [7:0]  ctrl;
    logic [15:0] txc;
  } vec_t;

  // rx0 rx1 tx0 tx2 det ract tact burst noenc | dtx ttx drx | setup ctrl txkey
  localparam vec_t VECS [10] = '{
    '{16'h0023, 16'h0000, 16'h8005, 16'h0000, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h01, 8'h41, 16'h8005},
    '{16'h0000, 16'h0010, 16'h0009, 16'h0012, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h80, 8'hE0, 16'h0012},
    '{16'h0000, 16'h0000, 16'h8023, 16'h0000, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h03, 8'h80, 16'h8023},
    '{16'h0000, 16'h0000, 16'h8023, 16'h0000, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 16'h8023},
    '{16'h0000, 16'h0000, 16'h8023, 16'h0000, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 16'h8023},
    '{16'h0000, 16'h0000, 16'h8023, 16'h0000, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 16'h8023},
    '{16'h0000, 16'h0010, 16'h0007, 16'h8001, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h80, 8'hE0, 16'h0007},
    '{16'h0000, 16'h0010, 16'h0000, 16'h8011, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h83, 8'hE0, 16'h8011},
    '{16'h0000, 16'h0010, 16'h0004, 16'h8033, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h80, 8'hE0, 16'h0004},
    '{16'h0031, 16'h0010, 16'h0006, 16'h8001, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h01, 8'hC1, 16'h0006}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NCH-1:0]    req = '0;
  logic              busy = 1'b0;
  logic [NCH-1:0]    ract = '0, tact = '0, burst = '0, noenc = '0;
  logic [NCH*2-1:0]  det = '0;
  logic [NCH*SB-1:0] rxc = '0, txc = '0;
  logic [CW-2:0]     dig_key, tone_key;
  logic [23:0]       dig_bytes;
  logic [15:0]       tone_bytes;
  logic              cmd_valid;
  logic [1:0]        cmd_chan;
  logic [7:0]        cmd_op, cmd_b1, cmd_b2;

  int checks = 0, errors = 0, cyc = 0, busy_cnt = 0, busy_viol = 0;
  int log_n = 0;
  logic [7:0] log_op [64];
  logic [7:0] log_b1 [64];
  logic [7:0] log_b2 [64];
  logic [1:0] log_ch [64];
  bit done = 0;

  always #4 clk = ~clk;

  function automatic logic [23:0] dig_lut(input logic [14:0] k);
    return {k[7:0] ^ 8'h11, k[7:0] ^ 8'h22, k[14:7] ^ 8'h33};
  endfunction
  function automatic logic [15:0] tone_lut(input logic [14:0] k);
    return {k[7:0] ^ 8'h44, k[14:7] ^ 8'h55};
  endfunction

  assign dig_bytes  = dig_lut(dig_key);
  assign tone_bytes = tone_lut(tone_key);

  tone_cfg_seq i_tone_cfg_seq (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .busy_i(busy),
    .rx_act_i(ract), .tx_act_i(tact), .burst_i(burst), .no_enc_i(noenc),
    .det_code_i(det), .rx_code_i(rxc), .tx_code_i(txc),
    .dig_key_o(dig_key), .dig_bytes_i(dig_bytes),
    .tone_key_o(tone_key), .tone_bytes_i(tone_bytes),
    .cmd_valid_o(cmd_valid), .cmd_chan_o(cmd_chan), .cmd_op_o(cmd_op),
    .cmd_b1_o(cmd_b1), .cmd_b2_o(cmd_b2)
  );

  // monitor and engine model
  always @(negedge clk) begin
    if (rst_n) begin
      if (cmd_valid) begin
        if (busy) busy_viol++;
        if (log_n < 64) begin
          log_op[log_n] = cmd_op;
          log_b1[log_n] = cmd_b1;
          log_b2[log_n] = cmd_b2;
          log_ch[log_n] = cmd_chan;
        end
        log_n++;
        busy_cnt = 3;
      end else if (busy_cnt > 0) begin
        busy_cnt--;
      end
      busy = (busy_cnt > 0);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      finish_run();
    end
  end

  task automatic chk(input bit ok, input string req_tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req_tag, act, exp);
    end
  endtask

  task automatic pulse(input logic [NCH-1:0] m);
    @(negedge clk); req = m;
    @(negedge clk); req = '0;
  endtask

  task automatic wait_cmds(input int target);
    for (int t = 0; t < 3000 && log_n < target; t++) @(negedge clk);
    repeat (30) @(negedge clk);
  endtask

  task automatic clear_cfg();
    ract = '0; tact = '0; burst = '0; noenc = '0; det = '0; rxc = '0; txc = '0;
  endtask

  task automatic run_vec(input int vi);
    vec_t v;
    int ch, base, n;
    logic [7:0]  e_op [9];
    logic [7:0]  e_b1 [9];
    logic [7:0]  e_b2 [9];
    logic [23:0] db;
    logic [15:0] tb;
    v = VECS[vi];
    ch = vi % NCH;
    @(negedge clk);
    clear_cfg();
    rxc[(ch*NSL+0)*CW +: CW] = v.rx0;
    rxc[(ch*NSL+1)*CW +: CW] = v.rx1;
    txc[(ch*NSL+0)*CW +: CW] = v.tx0;
    txc[(ch*NSL+2)*CW +: CW] = v.tx2;
    det[ch*2 +: 2] = v.det;
    ract[ch] = v.ract; tact[ch] = v.tact; burst[ch] = v.burst; noenc[ch] = v.noenc;
    n = 0;
    // R10 order: dig tx, tone tx, dig rx, setup, ctrl
    if (v.g_dtx) begin
      db = dig_lut(v.txc[14:0]);
      e_op[n] = 8'h84; e_b1[n] = db[23:16]; e_b2[n] = 8'h00; n++;
      e_op[n] = 8'h85; e_b1[n] = db[15:8];  e_b2[n] = 8'h00; n++;
      e_op[n] = 8'h86; e_b1[n] = db[7:0];   e_b2[n] = 8'h00; n++;
    end
    if (v.g_ttx) begin
      tb = tone_lut(v.txc[14:0]);
      e_op[n] = 8'h83; e_b1[n] = tb[15:8]; e_b2[n] = tb[7:0]; n++;
    end
    if (v.g_drx) begin
      db = dig_lut(v.rx0[14:0]);
      e_op[n] = 8'h84; e_b1[n] = db[23:16]; e_b2[n] = 8'h00; n++;
      e_op[n] = 8'h85; e_b1[n] = db[15:8];  e_b2[n] = 8'h00; n++;
      e_op[n] = 8'h86; e_b1[n] = db[7:0];   e_b2[n] = 8'h00; n++;
    end
    e_op[n] = 8'h8B; e_b1[n] = v.setup; e_b2[n] = 8'h00; n++;
    e_op[n] = 8'h8A; e_b1[n] = v.ctrl;  e_b2[n] = 8'h00; n++;
    base = log_n;
    pulse(NCH'(1 << ch));
    wait_cmds(base + n);
    chk(log_n == base + n, $sformatf("R10 vec%0d command count", vi), log_n - base, n);
    if (log_n == base + n) begin
      for (int k = 0; k < n; k++) begin
        chk(log_op[base+k] == e_op[k], $sformatf("R10 vec%0d op[%0d]", vi, k),
            int'(log_op[base+k]), int'(e_op[k]));
        chk(log_b1[base+k] == e_b1[k], $sformatf("R6/R7/R8/R9 vec%0d b1[%0d]", vi, k),
            int'(log_b1[base+k]), int'(e_b1[k]));
        if (e_op[k] == 8'h83)
          chk(log_b2[base+k] == e_b2[k], $sformatf("R7 vec%0d b2", vi),
              int'(log_b2[base+k]), int'(e_b2[k]));
        chk(int'(log_ch[base+k]) == ch, $sformatf("R9 vec%0d chan[%0d]", vi, k),
            int'(log_ch[base+k]), ch);
      end
    end
  endtask

  initial begin
    int base;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(cmd_valid == 1'b0, "R12 cmd_valid in reset", int'(cmd_valid), 0);
    @(negedge clk); rst_n = 1'b1;
    // R2 configured channels but no request: no command
    tact = '1; txc[CW-1:0] = 16'h8023;
    repeat (25) @(negedge clk);
    chk(log_n == 0, "R2 no command without request", log_n, 0);
    chk(cmd_valid == 1'b0, "R12 idle after reset", int'(cmd_valid), 0);

    // main table: R3 R4 R5 R6 R7 R8 R9 R10
    for (int i = 0; i < 10; i++) run_vec(i);

    // R11 round-robin: ch0 and ch1 pending, ch0 re-flagged during its own run
    @(negedge clk);
    clear_cfg();
    rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    base = log_n;
    pulse(4'b0011);
    for (int t = 0; t < 200 && log_n < base + 1; t++) @(negedge clk);
    pulse(4'b0001);
    wait_cmds(base + 6);
    chk(log_n == base + 6, "R11 three sequences", log_n - base, 6);
    chk(log_ch[base+1] == 2'd0, "R11 first served", int'(log_ch[base+1]), 0);
    chk(log_ch[base+3] == 2'd1, "R11 waiting channel served next", int'(log_ch[base+3]), 1);
    chk(log_ch[base+5] == 2'd0, "R11 re-flagged channel last", int'(log_ch[base+5]), 0);
    chk(log_op[base+1] == 8'h8A && log_op[base] == 8'h8B, "R9 setup then ctrl",
        int'(log_op[base+1]), 8'h8A);

    // R2 flag cleared on accept: no further sequence
    base = log_n;
    repeat (40) @(negedge clk);
    chk(log_n == base, "R2 flag cleared after accept", log_n - base, 0);

    // R1 never a command after a busy cycle
    chk(busy_viol == 0, "R1 command issued while busy", busy_viol, 0);

    finish_run();
  end

endmodule